// File: doc/BRIEF.md
# Masked Beam Position Comparator

This block decides whether a raster-wait or conditional-skip instruction has reached its target. It takes the live vertical and horizontal beam counters, the two 16-bit instruction words that encode the target position and the per-bit compare enables, and a flag that reports that the block-transfer engine has finished. It returns one registered flag, `cond_met`, which is high when the enabled beam bits are at or past the enabled target bits.

The vertical byte and horizontal bits 8..2 are joined into one 15-bit key, with the vertical byte on top. Because of this ordering, the vertical part decides the result, and the horizontal part matters only when the enabled vertical bits are equal. Each key bit has an enable bit in the second word, except vertical bit 7, which is always compared. A disabled bit is cleared on both sides before the unsigned compare, so it cannot change the result. The top bit of the second word can waive the transfer-finished gate.

The sequencer drives `beam_tick` for one cycle whenever the beam counters or the instruction words change. The result is captured on that edge and holds until the next tick. There is no back-pressure: every tick is accepted, and the output is a level, not a stream.

Top module: `beam_cmp_top`

## Requirements
- R1: While `rst_n` is low, and after reset until the first tick, `cond_met` is 0.
- R2: `cond_met` changes only on the clock edge where `beam_tick` is 1, and it shows that edge's inputs one cycle after the tick is driven. Without a tick it holds its value, whatever the other inputs do.
- R3: When all enables are set and the blitter gate is waived, `cond_met` is 1 exactly when {vpos[7:0], hpos[8:2]} >= {word1[15:8], word1[7:1]} as unsigned values.
- R4: With all vertical enables set, a beam vertical value above the target gives 1 regardless of the horizontal values. A beam vertical value below the target gives 0 regardless of the horizontal values.
- R5: When the vertical values are equal, the result follows hpos[8:2] >= word1[7:1]. Equal positions count as met.
- R6: hpos[1:0], word1[0] and word2[0] have no effect on the result.
- R7: word2[14:8] enable vertical bits 6..0 and word2[7:1] enable horizontal bits 8..2. A 0 enable removes that bit from both sides of the compare.
- R8: Vertical bit 7 is always compared, even when all enable bits in word2 are 0.
- R9: When word2[15] is 0, `cond_met` is 1 only if `blit_done` is also 1.
- R10: When word2[15] is 1, `blit_done` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beam_tick | input | 1 | Capture strobe for a beam or instruction update |
| vpos | input | 8 | Vertical beam counter |
| hpos | input | 9 | Horizontal beam counter |
| word1 | input | 16 | First instruction word: target vertical [15:8], target horizontal [7:1] |
| word2 | input | 16 | Second instruction word: gate waive [15], vertical enables [14:8], horizontal enables [7:1] |
| blit_done | input | 1 | Block-transfer engine finished flag |
| cond_met | output | 1 | Registered condition-met result |

## Verification
A wrong bit in the key layout or in the enable mapping shows up as a wrong `cond_met` on the cycle right after the tick that carries a position on either side of that bit. The vectors therefore place the beam just above, just below and exactly at the target in each field. If the capture enable is faulty, the output moves between ticks, and the bench sees this within a few idle cycles. A faulty gate shows up as the transfer-finished flag being honoured or ignored on the wrong polarity of word2[15].

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int WORD_W  = 16;
  localparam int VBITS   = 8;
  localparam int HBITS   = 9;
  localparam int HDROP   = 2;
  localparam int HKEEP   = HBITS - HDROP;
  localparam int KEY_W   = VBITS + HKEEP;
  localparam int V_LSB   = WORD_W - VBITS;
  localparam int H_LSB   = V_LSB - HKEEP;
  localparam int GATE_B  = WORD_W - 1;

  typedef logic [KEY_W-1:0] key_t;
endpackage

// File: rtl/bpc_key_build.sv
module bpc_key_build
  import bpc_pkg::*;
(
  input  logic [VBITS-1:0]  vpos,
  input  logic [HBITS-1:0]  hpos,
  input  logic [WORD_W-1:0] word1,
  input  logic [WORD_W-1:0] word2,
  output key_t              beam_key,
  output key_t              tgt_key
);
  key_t enable;
  key_t beam_raw;
  key_t tgt_raw;

  // vertical MSB has no enable bit: always compared
  assign enable   = {1'b1, word2[GATE_B-1:H_LSB]};
  assign beam_raw = {vpos, hpos[HBITS-1:HDROP]};
  assign tgt_raw  = word1[WORD_W-1:H_LSB];

  assign beam_key = beam_raw & enable;
  assign tgt_key  = tgt_raw & enable;
endmodule

// File: rtl/bpc_geq_chain.sv
module bpc_geq_chain #(
  parameter int N = 15
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic         geq
);
  logic [N:0] eq_pre;
  logic [N:0] gt_acc;

  assign eq_pre[N] = 1'b1;
  assign gt_acc[N] = 1'b0;

  for (genvar i = N - 1; i >= 0; i--) begin : g_bit
    assign eq_pre[i] = eq_pre[i+1] & (a[i] == b[i]);
    assign gt_acc[i] = gt_acc[i+1] | (eq_pre[i+1] & a[i] & ~b[i]);
  end

  assign geq = gt_acc[0] | eq_pre[0];
endmodule

// File: rtl/beam_cmp_top.sv
module beam_cmp_top
  import bpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beam_tick,
  input  logic [VBITS-1:0]  vpos,
  input  logic [HBITS-1:0]  hpos,
  input  logic [WORD_W-1:0] word1,
  input  logic [WORD_W-1:0] word2,
  input  logic              blit_done,
  output logic              cond_met
);
  key_t beam_key;
  key_t tgt_key;
  logic pos_ok;
  logic gate_ok;

  bpc_key_build u_keys (
    .vpos     (vpos),
    .hpos     (hpos),
    .word1    (word1),
    .word2    (word2),
    .beam_key (beam_key),
    .tgt_key  (tgt_key)
  );

  bpc_geq_chain #(.N(KEY_W)) u_cmp (
    .a   (beam_key),
    .b   (tgt_key),
    .geq (pos_ok)
  );

  assign gate_ok = word2[GATE_B] | blit_done;

  always_ff @(posedge clk) begin
    if (!rst_n)         cond_met <= 1'b0;
    else if (beam_tick) cond_met <= pos_ok & gate_ok;
  end
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker
  import bpc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              beam_tick,
  input logic [VBITS-1:0]  vpos,
  input logic [HBITS-1:0]  hpos,
  input logic [WORD_W-1:0] word1,
  input logic [WORD_W-1:0] word2,
  input logic              blit_done,
  input logic              cond_met
);
  logic live;
  always_ff @(posedge clk) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> !cond_met);  // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !beam_tick) |=> $stable(cond_met));  // R2

  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (beam_tick && !word2[GATE_B] && !blit_done) |=> !cond_met);  // R9

  AST_VMSB_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (beam_tick && !vpos[VBITS-1] && word1[WORD_W-1]) |=> !cond_met);  // R8

  AST_V_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (beam_tick && (&word2[GATE_B-1:V_LSB]) && word2[GATE_B]
     && (vpos > word1[WORD_W-1:V_LSB])) |=> cond_met);  // R4

  AST_V_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (beam_tick && (&word2[GATE_B-1:V_LSB])
     && (vpos < word1[WORD_W-1:V_LSB])) |=> !cond_met);  // R4
endmodule

bind beam_cmp_top bpc_checker u_bpc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .beam_tick (beam_tick),
  .vpos      (vpos),
  .hpos      (hpos),
  .word1     (word1),
  .word2     (word2),
  .blit_done (blit_done),
  .cond_met  (cond_met)
);

// File: tb/beam_cmp_top_test.sv
module beam_cmp_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        beam_tick = 1'b0;
  logic [7:0]  vpos = '0;
  logic [8:0]  hpos = '0;
  logic [15:0] word1 = '0;
  logic [15:0] word2 = '0;
  logic        blit_done = 1'b0;
  logic        cond_met;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  beam_cmp_top uut (
    .clk(clk), .rst_n(rst_n), .beam_tick(beam_tick), .vpos(vpos), .hpos(hpos),
    .word1(word1), .word2(word2), .blit_done(blit_done), .cond_met(cond_met)
  );

  // {vpos 8, hpos 9, word1 16, word2 16, blit_done 1, expected 1}
  localparam int NV = 13;
  localparam logic [50:0] VEC [NV] = '{
    {8'h40, 9'h050, 16'h4028, 16'hFFFE, 1'b0, 1'b1},  // R5 equal position met
    {8'h40, 9'h04C, 16'h4028, 16'hFFFE, 1'b0, 1'b0},  // R5 H just below
    {8'h41, 9'h000, 16'h4028, 16'hFFFE, 1'b0, 1'b1},  // R4 V above, H low
    {8'h3F, 9'h1FF, 16'h4028, 16'hFFFE, 1'b0, 1'b0},  // R4 V below, H high
    {8'h40, 9'h053, 16'h4029, 16'hFFFF, 1'b0, 1'b1},  // R6 low bits ignored
    {8'h10, 9'h050, 16'h7F28, 16'h80FE, 1'b0, 1'b1},  // R7 V enables off
    {8'h40, 9'h000, 16'h40FE, 16'hFF00, 1'b0, 1'b1},  // R7 H enables off
    {8'h7F, 9'h1FF, 16'h8000, 16'h8000, 1'b0, 1'b0},  // R8 V7 still compared
    {8'h80, 9'h000, 16'hFF00, 16'h8000, 1'b0, 1'b1},  // R8 V7 met
    {8'hFF, 9'h1FF, 16'h0000, 16'h7FFE, 1'b0, 1'b0},  // R9 gate blocks
    {8'hFF, 9'h1FF, 16'h0000, 16'h7FFE, 1'b1, 1'b1},  // R9 gate passes
    {8'hFF, 9'h1FF, 16'h0000, 16'hFFFE, 1'b0, 1'b1},  // R10 gate waived
    {8'h12, 9'h0A4, 16'h1252, 16'hFFFE, 1'b0, 1'b1}   // R3 exact key match
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1:   return "R5";
      2, 3:   return "R4";
      4:      return "R6";
      5, 6:   return "R7";
      7, 8:   return "R8";
      9, 10:  return "R9";
      11:     return "R10";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: cond_met=%0b expected %0b", req, got, exp);
    end
  endtask

  task automatic apply(logic [7:0] v, logic [8:0] h, logic [15:0] w1,
                       logic [15:0] w2, logic b);
    @(negedge clk);
    vpos = v; hpos = h; word1 = w1; word2 = w2; blit_done = b;
    beam_tick = 1'b1;
    @(negedge clk);
    beam_tick = 1'b0;
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", cond_met, 1'b0);
    rst_n = 1'b1;
    // inputs that would give 1, no tick yet: must stay 0
    vpos = 8'hFF; hpos = 9'h1FF; word2 = 16'hFFFE;
    repeat (2) @(negedge clk);
    check("R1", cond_met, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][50:43], VEC[i][42:34], VEC[i][33:18], VEC[i][17:2], VEC[i][1]);
      check(tag_of(i), cond_met, VEC[i][0]);
    end

    // R2: hold without tick, then update on tick
    apply(8'hFF, 9'h1FF, 16'h0000, 16'hFFFE, 1'b0);
    check("R2", cond_met, 1'b1);
    @(negedge clk);
    vpos = 8'h00; word1 = 16'hFF00;
    repeat (3) @(negedge clk);
    check("R2", cond_met, 1'b1);
    beam_tick = 1'b1;
    @(negedge clk);
    beam_tick = 1'b0;
    check("R2", cond_met, 1'b0);

    // R3: one below the target key at the horizontal LSB
    apply(8'h12, 9'h0A0, 16'h1252, 16'hFFFE, 1'b0);
    check("R3", cond_met, 1'b0);

    // R1: reset clears a set output
    apply(8'hFF, 9'h1FF, 16'h0000, 16'hFFFE, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", cond_met, 1'b0);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule